// File: doc/BRIEF.md
# Colour Channel Multiplexer Sequencer

This block drives the colour select of a single converter that is shared between red, green and blue pixel inputs, and labels each converter result with the colour it was sampled on. In three-channel mode the select steps through the three colours, one step per converter clock, so each colour is visited once per pixel. In single-channel mode the select holds one colour, taken from a configuration field or, when the external-control pin is low, from a pair of control pins.

An active-low start-of-line strobe re-anchors the rotation to red and flushes the tag history. The converter result arrives three converter clocks after its sample. The block keeps a short history of select values so that each output word carries the colour, a valid flag and a first-pixel marker that belong to the sample it came from. Colour codes are red 00, green 01 and blue 10. Code 11 is reserved.

Top module: `chan_mux_seq`

## Requirements
- R1: When `line_start_n` is low at a rising edge, the rotation returns to red, so in three-channel mode `colour_sel` reads 00 in the cycle that follows.
- R2: In three-channel mode (`single_mode` low), `colour_sel` advances red 00, green 01, blue 10, then red again, at each rising edge where `line_start_n` is high.
- R3: In single-channel mode with `ext_ctl_n` high, `colour_sel` equals `cfg_colour` in the same cycle.
- R4: In single-channel mode with `ext_ctl_n` low, `colour_sel` equals `pin_colour` in the same cycle.
- R5: In single-channel mode, a selected code of 11 drives `colour_sel` to red and sets `sel_err` after the next rising edge. `sel_err` stays set until `rst`.
- R6: After each rising edge, `out_word` shows the `adc_word` sampled at that edge, and `out_tag` shows the `colour_sel` value sampled three edges earlier.
- R7: `out_valid` is low after reset and after any edge where `line_start_n` is low. If the strobe is low at edge E0 and high from edge E1 onward, `out_valid` first rises after edge E4.
- R8: `out_first` is high only on the first valid word tagged red after a line reset or reset, and only when that word is valid.
- R9: While `rst` is high at a rising edge, the rotation goes to red, and `out_word`, `out_valid`, `out_first` and `sel_err` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_n | input | 1 | Start-of-line strobe, active low |
| single_mode | input | 1 | 1 = hold one colour, 0 = rotate |
| ext_ctl_n | input | 1 | 0 = control pins select colour, 1 = configuration field selects |
| cfg_colour | input | 2 | Configured single-channel colour |
| pin_colour | input | 2 | Externally driven colour select |
| adc_word | input | 12 | Converter result (belongs to the sample three edges earlier) |
| colour_sel | output | 2 | Colour select to the input multiplexer |
| sel_err | output | 1 | Sticky flag: reserved colour code was used |
| out_word | output | 12 | Registered converter result |
| out_tag | output | 2 | Colour of `out_word` |
| out_valid | output | 1 | `out_word` holds a real sample |
| out_first | output | 1 | First red word after a line reset |

## Verification
The select is combinational, so the bench checks `colour_sel` 1 ns after it drives inputs, before the next rising edge. `sel_err`, `out_word`, `out_valid`, `out_tag` and `out_first` are all due one edge after the stimulus that sets them, and the bench checks them at the following falling edge. The tag in each output word pairs with the select from three edges earlier, so the bench model keeps its own three-deep history of the select values it expected. On a line reset it flushes that history, which reproduces the four-edge gap before valid data returns.

// File: rtl/chmux_pkg.sv
`timescale 1ns/1ps
package chmux_pkg;

    typedef enum logic [1:0] {
        COL_RED   = 2'd0,
        COL_GREEN = 2'd1,
        COL_BLUE  = 2'd2,
        COL_RSVD  = 2'd3
    } colour_e;

    typedef struct packed {
        logic    valid;
        logic    first;
        colour_e tag;
    } tag_t;

    function automatic colour_e colour_next(colour_e c);
        case (c)
            COL_RED:   return COL_GREEN;
            COL_GREEN: return COL_BLUE;
            default:   return COL_RED;
        endcase
    endfunction

    function automatic colour_e colour_legal(logic [1:0] code);
        return (code == 2'b11) ? COL_RED : colour_e'(code);
    endfunction

endpackage

// File: rtl/colour_rotor.sv
`timescale 1ns/1ps
module colour_rotor
    import chmux_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    line_start_n,
    output colour_e rot
);

    always_ff @(posedge clk) begin
        if (rst || !line_start_n)
            rot <= COL_RED;
        else
            rot <= colour_next(rot);
    end

    AST_LINE_RED: assert property (@(posedge clk) disable iff (rst)
        !line_start_n |=> (rot == COL_RED)); // R1

    AST_ROT_ORDER: assert property (@(posedge clk) disable iff (rst)
        line_start_n |=> (rot == colour_next($past(rot)))); // R2

endmodule

// File: rtl/colour_source.sv
`timescale 1ns/1ps
module colour_source
    import chmux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       single_mode,
    input  logic       ext_ctl_n,
    input  logic [1:0] cfg_code,
    input  logic [1:0] pin_code,
    input  colour_e    rot,
    output colour_e    sel,
    output logic       sel_err
);

    logic [1:0] raw_code;

    always_comb begin
        raw_code = ext_ctl_n ? cfg_code : pin_code;
        sel      = single_mode ? colour_legal(raw_code) : rot;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_err <= 1'b0;
        else if (single_mode && raw_code == 2'b11)
            sel_err <= 1'b1;
    end

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sel != COL_RSVD); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        sel_err |=> sel_err); // R5

endmodule

// File: rtl/tag_pipe.sv
`timescale 1ns/1ps
module tag_pipe
    import chmux_pkg::*;
#(
    parameter int LAT    = 3,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start_n,
    input  colour_e           sample_tag,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output tag_t              tag_out
);

    localparam int LAST = LAT - 1;

    tag_t hist [LAT];
    logic pend;
    logic flush;

    assign flush = rst || !line_start_n;

    always_ff @(posedge clk) begin
        if (rst) data_out <= '0;
        else     data_out <= data_in;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            pend    <= 1'b1;
            tag_out <= '0;
            hist[0] <= '0;
        end else begin
            tag_out <= hist[LAST];
            hist[0] <= '{valid: 1'b1,
                         first: pend && (sample_tag == COL_RED),
                         tag:   sample_tag};
            if (sample_tag == COL_RED)
                pend <= 1'b0;
        end
    end

    generate
        for (genvar i = 1; i < LAT; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (flush) hist[i] <= '0;
                else       hist[i] <= hist[i-1];
            end
        end
    endgenerate

    AST_FLUSH_INVALID: assert property (@(posedge clk) disable iff (rst)
        !line_start_n |=> !tag_out.valid); // R7

    AST_FIRST_RED: assert property (@(posedge clk) disable iff (rst)
        tag_out.first |-> (tag_out.valid && tag_out.tag == COL_RED)); // R8

    AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
        tag_out.first |=> !tag_out.first); // R8

endmodule

// File: rtl/chan_mux_seq.sv
`timescale 1ns/1ps
module chan_mux_seq
    import chmux_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start_n,
    input  logic              single_mode,
    input  logic              ext_ctl_n,
    input  logic [1:0]        cfg_colour,
    input  logic [1:0]        pin_colour,
    input  logic [DATA_W-1:0] adc_word,
    output logic [1:0]        colour_sel,
    output logic              sel_err,
    output logic [DATA_W-1:0] out_word,
    output logic [1:0]        out_tag,
    output logic              out_valid,
    output logic              out_first
);

    colour_e rot;
    colour_e sel;
    tag_t    tag_q;

    colour_rotor u_rotor (
        .clk          (clk),
        .rst          (rst),
        .line_start_n (line_start_n),
        .rot          (rot)
    );

    colour_source u_source (
        .clk         (clk),
        .rst         (rst),
        .single_mode (single_mode),
        .ext_ctl_n   (ext_ctl_n),
        .cfg_code    (cfg_colour),
        .pin_code    (pin_colour),
        .rot         (rot),
        .sel         (sel),
        .sel_err     (sel_err)
    );

    tag_pipe #(.LAT(LATENCY), .DATA_W(DATA_W)) u_pipe (
        .clk          (clk),
        .rst          (rst),
        .line_start_n (line_start_n),
        .sample_tag   (sel),
        .data_in      (adc_word),
        .data_out     (out_word),
        .tag_out      (tag_q)
    );

    assign colour_sel = sel;
    assign out_tag    = tag_q.tag;
    assign out_valid  = tag_q.valid;
    assign out_first  = tag_q.first;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_first && !sel_err)); // R9

endmodule

// File: tb/sim_chan_mux_seq.sv
`timescale 1ns/1ps
module sim_chan_mux_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start_n = 1'b1;
    logic        single_mode = 1'b0;
    logic        ext_ctl_n = 1'b1;
    logic [1:0]  cfg_colour = 2'd0;
    logic [1:0]  pin_colour = 2'd0;
    logic [11:0] adc_word = 12'd0;
    logic [1:0]  colour_sel;
    logic        sel_err;
    logic [11:0] out_word;
    logic [1:0]  out_tag;
    logic        out_valid;
    logic        out_first;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [1:0]  m_rot;
    logic        m_pend, m_err, m_ov, m_of;
    logic [1:0]  m_ot;
    logic [11:0] m_word;
    logic        h_v [3];
    logic        h_f [3];
    logic [1:0]  h_t [3];
    logic        prev_ls = 1'b1;

    always #2.5 clk = ~clk;

    chan_mux_seq u0 (
        .clk(clk), .rst(rst), .line_start_n(line_start_n),
        .single_mode(single_mode), .ext_ctl_n(ext_ctl_n),
        .cfg_colour(cfg_colour), .pin_colour(pin_colour),
        .adc_word(adc_word), .colour_sel(colour_sel), .sel_err(sel_err),
        .out_word(out_word), .out_tag(out_tag),
        .out_valid(out_valid), .out_first(out_first)
    );

    function automatic logic [1:0] nxt(logic [1:0] c);
        return (c == 2'd2) ? 2'd0 : c + 2'd1;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_rot = 2'd0; m_pend = 1'b1; m_ov = 1'b0; m_of = 1'b0; m_ot = 2'd0;
        for (int i = 0; i < 3; i++) begin h_v[i] = 1'b0; h_f[i] = 1'b0; h_t[i] = 2'd0; end
    endtask

    task automatic do_reset();
        rst = 1'b1; line_start_n = 1'b1; single_mode = 1'b0; adc_word = '0;
        repeat (2) @(posedge clk);
        model_clear(); m_word = '0; m_err = 1'b0; prev_ls = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(colour_sel == 2'd0, "R9 sel", colour_sel, 0);
        check(!out_valid && !out_first, "R9 valid/first", out_valid, 0);
        check(out_word == 12'd0, "R9 word", out_word, 0);
        check(!sel_err, "R9/R5 err cleared", sel_err, 0);
    endtask

    task automatic cycle(input logic ls, input logic sm, input logic en,
                         input logic [1:0] cf, input logic [1:0] pc, input logic [11:0] w);
        logic [1:0] raw, exp_sel;
        string req;
        line_start_n = ls; single_mode = sm; ext_ctl_n = en;
        cfg_colour = cf; pin_colour = pc; adc_word = w;
        #1;
        raw = en ? cf : pc;
        if (sm) begin
            exp_sel = (raw == 2'd3) ? 2'd0 : raw;
            req = (raw == 2'd3) ? "R5 sel" : (en ? "R3 sel" : "R4 sel");
        end else begin
            exp_sel = m_rot;
            req = prev_ls ? "R2 sel" : "R1 sel";
        end
        check(colour_sel == exp_sel, req, colour_sel, exp_sel);
        @(posedge clk);
        m_word = w;
        if (sm && raw == 2'd3) m_err = 1'b1;
        if (!ls) begin
            model_clear();
        end else begin
            m_ov = h_v[2]; m_ot = h_t[2]; m_of = h_f[2];
            for (int i = 2; i > 0; i--) begin h_v[i] = h_v[i-1]; h_t[i] = h_t[i-1]; h_f[i] = h_f[i-1]; end
            h_v[0] = 1'b1; h_t[0] = exp_sel; h_f[0] = m_pend && (exp_sel == 2'd0);
            if (exp_sel == 2'd0) m_pend = 1'b0;
            m_rot = nxt(m_rot);
        end
        prev_ls = ls;
        @(negedge clk);
        check(out_word == m_word, "R6 word", out_word, m_word);
        check(out_valid == m_ov, "R7 valid", out_valid, m_ov);
        if (m_ov) check(out_tag == m_ot, "R6 tag", out_tag, m_ot);
        check(out_first == m_of, "R8 first", out_first, m_of);
        check(sel_err == m_err, "R5 err", sel_err, m_err);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // R1/R2/R7/R8: line strobe then three-channel rotation
        cycle(1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 12'h111);
        for (int k = 0; k < 14; k++) cycle(1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 12'(k * 37));
        // mid-line strobe re-anchors (R1)
        cycle(1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 12'h0AA);
        cycle(1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 12'h0BB);
        for (int k = 0; k < 8; k++) cycle(1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 12'(k + 500));
        // R3: config field selects green then blue
        for (int k = 0; k < 6; k++) cycle(1'b1, 1'b1, 1'b1, 2'd1, 2'd2, 12'(k));
        for (int k = 0; k < 6; k++) cycle(1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 12'(k));
        // R4: pins select
        cycle(1'b0, 1'b1, 1'b0, 2'd1, 2'd2, 12'h321);
        for (int k = 0; k < 6; k++) cycle(1'b1, 1'b1, 1'b0, 2'd1, 2'(k % 3), 12'(k));
        // R5: reserved code from pins, then stays set
        cycle(1'b1, 1'b1, 1'b0, 2'd0, 2'd3, 12'h7FF);
        for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 12'(k));
        // random mix
        for (int k = 0; k < 1500; k++) begin
            logic ls, sm, en;
            logic [1:0] cf, pc;
            ls = ($urandom % 16) != 0;
            sm = ($urandom % 3) == 0;
            en = $urandom % 2;
            cf = (($urandom % 40) == 0) ? 2'd3 : 2'($urandom % 3);
            pc = (($urandom % 40) == 0) ? 2'd3 : 2'($urandom % 3);
            cycle(ls, sm, en, cf, pc, 12'($urandom));
        end
        // R9/R5: reset clears sticky flag
        do_reset();
        cycle(1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 12'h555);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule